// File: doc/BRIEF.md
# Per-Queue Packet-Ready Tracker

This block sits next to a multi-queue buffer whose write and read ports both carry 36-bit words. It keeps a count of complete packets in each queue and reports a packet-ready bit for each queue. A consumer can then drain a queue a whole packet at a time and never stall partway through a packet. The block stores no data. It watches the enables and queue selects of both ports, the start and end markers on each written word, and the end marker on each word read out.

A packet opens on a written word that carries the start marker. It closes on a later word to the same queue that carries the end marker. A single word may carry both markers. Each closed packet adds one to that queue's count. Each word read out with the end marker removes one. A partial reset clears the count and the framing state of one queue and leaves the other queues untouched.

The buffer beside this block owns all data movement and back-pressure. The enables seen here mark words that were actually written or read. For that reason every pin is a plain control or status signal, with no valid/ready handshake.

Top module: `pkt_ready_tracker`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `pkt_ready` is all zeros.
- R2: A write (`wr_en`=1) to queue q with `wr_eop`=1 counts as a completed packet when `wr_sop`=1 on that word or when an earlier start word to q left a packet open. `pkt_ready[q]` reflects the new count after the clock edge that takes the write.
- R3: A write with `wr_eop`=1 and `wr_sop`=0 to a queue with no open packet is ignored. It leaves the count unchanged.
- R4: A read (`rd_en`=1) from queue q with `rd_eop`=1 lowers q's count by one. `pkt_ready[q]` falls after the edge at which the count reaches zero.
- R5: An end-marked read from a queue whose count is zero has no effect, so the count never underflows.
- R6: In one cycle, a counted end-marked write and an end-marked read on the same queue leave that queue's count unchanged.
- R7: A queue's count saturates at 2^CNT_W-1, which is 15 by default. Further completed packets do not raise it, and it does not wrap.
- R8: `prst_en`=1 with `prst_qsel`=q clears q's count and open-packet state at the next edge. This takes priority over a write or read to q in the same cycle.
- R9: Every queue is tracked on its own. Writes, reads and partial resets aimed at one queue never change another queue's `pkt_ready` bit.
- R10: Markers have no effect while their enable is low, and a read with `rd_eop`=0 never changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A word is written this cycle |
| wr_qsel | input | QW (2) | Queue receiving the written word |
| wr_sop | input | 1 | Written word starts a packet |
| wr_eop | input | 1 | Written word ends a packet |
| rd_en | input | 1 | A word is read this cycle |
| rd_qsel | input | QW (2) | Queue the word is read from |
| rd_eop | input | 1 | Read word ends a packet |
| prst_en | input | 1 | Partial reset of one queue |
| prst_qsel | input | QW (2) | Queue to partially reset |
| pkt_ready | output | NUM_Q (4) | Bit q high when queue q holds at least one complete packet |

## Verification
A wrong count usually stays hidden until the read side drains the queue. A count that is too high keeps `pkt_ready` asserted after the last packet has left. A count that is too low drops it while a packet is still waiting. The tests therefore pair each disturbance (orphan end marker, underflow attempt, saturation, simultaneous update, partial reset) with a drain sequence that exposes the error within a few cycles. Stale open-packet state shows up as an end-only write being counted when it should not be, so the partial-reset test closes a half-written packet after the reset and expects no ready bit.

// File: rtl/pkt_tracker_pkg.sv
package pkt_tracker_pkg;
  typedef enum logic {
    FRAME_IDLE = 1'b0,
    FRAME_OPEN = 1'b1
  } frame_state_e;
endpackage

// File: rtl/pkt_sel_decode.sv
module pkt_sel_decode #(
  parameter int NUM_Q = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             en,
  input  logic [QW-1:0]    qsel,
  output logic [NUM_Q-1:0] hit
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_hit
    assign hit[q] = en && (qsel == QW'(q));
  end
endmodule

// File: rtl/pkt_wr_framer.sv
module pkt_wr_framer
  import pkt_tracker_pkg::*;
#(
  parameter int NUM_Q = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] wr_hit,
  input  logic             sop,
  input  logic             eop,
  input  logic [NUM_Q-1:0] clr,
  output logic [NUM_Q-1:0] done
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_frame
    frame_state_e st_q, st_d;

    // end marker closes a packet opened earlier or on this same word
    assign done[q] = wr_hit[q] && eop && (sop || (st_q == FRAME_OPEN));

    always_comb begin
      st_d = st_q;
      if (clr[q])          st_d = FRAME_IDLE;
      else if (wr_hit[q]) begin
        if (eop)           st_d = FRAME_IDLE;
        else if (sop)      st_d = FRAME_OPEN;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= FRAME_IDLE;
      else        st_q <= st_d;
    end
  end
endmodule

// File: rtl/pkt_q_counter.sv
module pkt_q_counter #(
  parameter int CNT_W = 4,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             nonzero
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                           cnt_d = '0;
    else if (inc && !dec) begin
      if (cnt != CNT_MAX)              cnt_d = cnt + 1'b1;
    end else if (dec && !inc) begin
      if (cnt != '0)                   cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign nonzero = (cnt != '0);
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker #(
  parameter int NUM_Q = 4,
  parameter int CNT_W = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_qsel,
  input  logic             wr_sop,
  input  logic             wr_eop,
  input  logic             rd_en,
  input  logic [QW-1:0]    rd_qsel,
  input  logic             rd_eop,
  input  logic             prst_en,
  input  logic [QW-1:0]    prst_qsel,
  output logic [NUM_Q-1:0] pkt_ready
);
  logic [NUM_Q-1:0]       wr_hit, rd_hit, clr_v, inc_v, dec_v;
  logic [NUM_Q*CNT_W-1:0] cnt_flat;

  pkt_sel_decode #(.NUM_Q(NUM_Q)) u_wr_dec (
    .en(wr_en), .qsel(wr_qsel), .hit(wr_hit));
  pkt_sel_decode #(.NUM_Q(NUM_Q)) u_rd_dec (
    .en(rd_en && rd_eop), .qsel(rd_qsel), .hit(rd_hit));
  pkt_sel_decode #(.NUM_Q(NUM_Q)) u_pr_dec (
    .en(prst_en), .qsel(prst_qsel), .hit(clr_v));

  pkt_wr_framer #(.NUM_Q(NUM_Q)) u_framer (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .sop(wr_sop), .eop(wr_eop),
    .clr(clr_v), .done(inc_v));

  assign dec_v = rd_hit;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_cnt
    pkt_q_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_v[q]), .dec(dec_v[q]), .clr(clr_v[q]),
      .cnt(cnt_flat[q*CNT_W +: CNT_W]), .nonzero(pkt_ready[q]));
  end
endmodule

// File: rtl/pkt_tracker_chk.sv
module pkt_tracker_chk #(
  parameter int NUM_Q = 4,
  parameter int CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_Q-1:0]       inc_v,
  input logic [NUM_Q-1:0]       dec_v,
  input logic [NUM_Q-1:0]       clr_v,
  input logic [NUM_Q*CNT_W-1:0] cnt_flat,
  input logic [NUM_Q-1:0]       pkt_ready
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> pkt_ready == '0);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    wire [CNT_W-1:0] c = cnt_flat[q*CNT_W +: CNT_W];

    a_r2_inc_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v[q] && !dec_v[q] && !clr_v[q]) |=> pkt_ready[q]);
    a_r4_last_read: assert property (@(posedge clk) disable iff (!rst_n)
      (c == CNT_W'(1) && dec_v[q] && !inc_v[q]) |=> !pkt_ready[q]);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (c == '0 && !inc_v[q]) |=> c == '0);
    a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v[q] && dec_v[q] && !clr_v[q]) |=> $stable(c));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (c == {CNT_W{1'b1}} && !dec_v[q] && !clr_v[q]) |=> c == {CNT_W{1'b1}});
    a_r8_prst_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v[q] |=> !pkt_ready[q]);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_v[q] && !dec_v[q] && !clr_v[q]) |=> $stable(pkt_ready[q]));
  end
endmodule

bind pkt_ready_tracker pkt_tracker_chk #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_v(inc_v), .dec_v(dec_v), .clr_v(clr_v),
  .cnt_flat(cnt_flat), .pkt_ready(pkt_ready));

// File: tb/test_pkt_ready_tracker.sv
module test_pkt_ready_tracker;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, rd_en = 0, rd_eop = 0, prst_en = 0;
  logic [1:0] wr_qsel = 0, rd_qsel = 0, prst_qsel = 0;
  logic [3:0] pkt_ready;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pkt_ready_tracker i_pkt_ready_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_qsel(wr_qsel), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .rd_en(rd_en), .rd_qsel(rd_qsel), .rd_eop(rd_eop),
    .prst_en(prst_en), .prst_qsel(prst_qsel), .pkt_ready(pkt_ready));

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if (pkt_ready !== exp) begin
      failures++;
      $display("FAIL %s: pkt_ready actual=%b expected=%b", req, pkt_ready, exp);
    end
  endtask

  // drive one cycle at the falling edge, return after the next falling edge
  task automatic cyc(logic we, logic [1:0] wq, logic s, logic e,
                     logic re, logic [1:0] rq, logic reo,
                     logic pe, logic [1:0] pq);
    wr_en = we; wr_qsel = wq; wr_sop = s; wr_eop = e;
    rd_en = re; rd_qsel = rq; rd_eop = reo; prst_en = pe; prst_qsel = pq;
    @(negedge clk);
    wr_en = 0; wr_sop = 0; wr_eop = 0; rd_en = 0; rd_eop = 0; prst_en = 0;
  endtask

  task automatic wr(logic [1:0] q, logic s, logic e);
    cyc(1, q, s, e, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(logic [1:0] q, logic e);
    cyc(0, 0, 0, 0, 1, q, e, 0, 0);
  endtask

  task automatic t_reset;
    check("R1 reset", 4'b0000);
  endtask

  task automatic t_single;
    wr(0, 1, 1);
    check("R2 single-word packet", 4'b0001);
    rd(0, 1);
    check("R4 drain q0", 4'b0000);
  endtask

  task automatic t_multiword;
    wr(1, 1, 0);
    check("R2 open not ready", 4'b0000);
    wr(1, 0, 0);
    wr(1, 0, 1);
    check("R2 close q1", 4'b0010);
    rd(1, 0); rd(1, 0);
    check("R10 non-eop reads", 4'b0010);
    rd(1, 1);
    check("R4 drain q1", 4'b0000);
  endtask

  task automatic t_orphan;
    wr(2, 0, 1);
    check("R3 orphan eop", 4'b0000);
    cyc(0, 2, 1, 1, 0, 0, 0, 0, 0);
    check("R10 wr_en low", 4'b0000);
    wr(2, 0, 1);
    check("R10 no open after disabled sop", 4'b0000);
  endtask

  task automatic t_underflow;
    rd(3, 1);
    wr(3, 1, 1);
    check("R5 no underflow", 4'b1000);
    rd(3, 1);
    check("R5 drain", 4'b0000);
    cyc(0, 0, 0, 0, 0, 3, 1, 0, 0);
    wr(3, 1, 1);
    check("R10 rd_en low", 4'b1000);
    rd(3, 1);
  endtask

  task automatic t_simul;
    wr(0, 1, 1);
    cyc(1, 0, 1, 1, 1, 0, 1, 0, 0);
    check("R6 simultaneous", 4'b0001);
    rd(0, 1);
    check("R6 one left", 4'b0000);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 17; i++) wr(2, 1, 1);
    for (int i = 0; i < 14; i++) rd(2, 1);
    check("R7 after 14 reads", 4'b0100);
    rd(2, 1);
    check("R7 saturated at 15", 4'b0000);
  endtask

  task automatic t_prst;
    wr(1, 1, 1); wr(1, 1, 1); wr(3, 1, 1);
    check("R9 two queues", 4'b1010);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
    check("R8 prst q1 only", 4'b1000);
    cyc(1, 1, 1, 1, 0, 0, 0, 1, 1);
    check("R8 prst beats write", 4'b1000);
    wr(1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
    wr(1, 0, 1);
    check("R8 open state cleared", 4'b1000);
    rd(3, 1);
    check("R9 q3 drained", 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_single;
    t_multiword;
    t_orphan;
    t_underflow;
    t_simul;
    t_saturate;
    t_prst;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule